// File: doc/BRIEF.md
# Diagnostic Port Write Snooper

This block sits on a shared parallel bus on which every target sees every transaction, in the manner of a classic broadcast expansion bus. Boot firmware reports its progress by writing one-byte progress codes to I/O port 0x80. The block picks those writes out of the traffic, keeps the most recent code on its outputs, and drives a four-digit hex view for a seven-segment display. When firmware hangs, the code left on the display shows the last step that completed.

A transaction starts with an address phase. In that cycle the master presents the address, a write flag and an I/O-space flag. A target then has two cycles to assert its claim line. Once a claim is seen, the master drives the data, and the claiming target ends the transaction with an acknowledge. The block follows one of three claim policies:
- **Eager:** it claims at once.
- **Polite:** it waits one cycle. If another target has already claimed, it listens without claiming.
- **Listen-only:** it never claims. It only records data from transactions that some other target claims.

A wide mode also accepts writes to port 0x81. Such a write holds a high byte until the next port 0x80 write, which then forms a 16-bit code.

Top module: `post_code_snooper`

## Requirements
- R1: Only a write (`bus_write`=1) in I/O space (`bus_io`=1) to address 0x80, or to 0x81 when `cfg_wide`=1, is a match. Reads, memory-space writes, other addresses, and 0x81 with `cfg_wide`=0 never raise `snp_claim`, `snp_ack` or `code_valid`, and leave `code_out` unchanged.
- R2: With `cfg_policy`=0 (eager), `snp_claim` is high in the cycle right after a matching address phase.
- R3: With `cfg_policy`=1 (polite), `snp_claim` is low in the first cycle after the address phase. If `bus_other_claim` is high in that cycle, the block never drives claim or ack for that transaction and records the data at the other target's ack. Otherwise `snp_claim` rises in the second cycle.
- R4: With `cfg_policy`=2 or 3 (listen-only), the block never drives `snp_claim` or `snp_ack`. It records the data when another target claims in the first or second cycle after the address phase.
- R5: If no target claims in the two cycles after a matching address phase, the transaction is aborted. No code is recorded, and data or ack that follow are ignored.
- R6: As claimant, the block holds `snp_claim` from its first claim cycle through its ack cycle. It raises `snp_ack` for exactly one cycle, the cycle after the first cycle with `bus_data_valid` high, and drops both lines in the next cycle.
- R7: `code_valid` is a one-cycle pulse in the first cycle a new code shows on `code_out`. The code is otherwise held unchanged. As claimant this is the ack cycle. When snooping it is the cycle after the other target's ack.
- R8: With `cfg_wide`=0, a recorded byte b gives `code_out` = {8'h00, b}, and `digit_en` = 4'b0011.
- R9: With `cfg_wide`=1, a write to 0x81 stores a pending high byte without changing `code_out` or pulsing `code_valid`. A following write to 0x80 gives `code_out` = {pending, low byte}, and `digit_en` = 4'b1111.
- R10: `seg_out[7i+6:7i]` shows nibble i of `code_out` as active-high segments {g,f,e,d,c,b,a}: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 b=7C C=39 d=5E E=79 F=71. A digit whose `digit_en` bit is 0 shows 7'h00.
- R11: Synchronous active-high reset clears `code_out` and the pending high byte to zero, and drives `code_valid`, `snp_claim` and `snp_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_policy | input | 2 | Claim policy: 0 eager, 1 polite, 2/3 listen-only |
| cfg_wide | input | 1 | Enables the 16-bit code using port 0x81 |
| bus_addr_valid | input | 1 | Address phase marker |
| bus_addr | input | 16 | Transaction address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_io | input | 1 | 1 = I/O space, 0 = memory space |
| bus_data | input | 8 | Write data byte |
| bus_data_valid | input | 1 | Master is driving the data phase |
| bus_other_claim | input | 1 | Claim line of the other targets |
| bus_other_ack | input | 1 | Acknowledge from another target |
| snp_claim | output | 1 | Claim driven by this block |
| snp_ack | output | 1 | Acknowledge driven by this block |
| code_out | output | 16 | Most recent progress code |
| code_valid | output | 1 | One-cycle pulse with a new code |
| seg_out | output | 28 | Seven-segment patterns, 7 bits per digit |
| digit_en | output | 4 | Digits that are lit |

## Verification
Matching writes are run under each policy with the competing target absent, claiming in the first window cycle, or claiming in the second. Comparing these runs shows which target ends up owning the transaction, and the exact cycle in which the code appears. Reads, memory writes, a neighbouring port and port 0x81 in narrow mode are each paired with a foreign claim, so a decode slip shows as a spurious claim or a changed code. The wide-mode run stages a high byte before the low one, so a premature update or a lost byte is distinguishable from correct assembly. An aborted transaction followed by a stray ack shows whether the block wrongly latches unclaimed data.

// File: rtl/post_snoop_pkg.sv
package post_snoop_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 2 * BYTE_W;
    localparam int NDIG   = CODE_W / 4;
    localparam int SEG_W  = 7;

    typedef enum logic [1:0] {
        POL_EAGER  = 2'd0,
        POL_POLITE = 2'd1,
        POL_LISTEN = 2'd2,
        POL_QUIET  = 2'd3
    } claim_policy_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN1,
        ST_WIN2,
        ST_OWN_DATA,
        ST_OWN_ACK,
        ST_SNOOP
    } snoop_state_e;

    typedef struct packed {
        logic hit;
        logic upper;
    } port_hit_t;

    typedef struct packed {
        logic              strobe;
        logic              upper;
        logic [BYTE_W-1:0] data;
    } capture_t;

    function automatic logic [SEG_W-1:0] hex_seg(input logic [3:0] n);
        logic [SEG_W-1:0] s;
        case (n)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/post_port_decode.sv
module post_port_decode
    import post_snoop_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] LO_PORT = 16'h0080
) (
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              is_io,
    input  logic              wide,
    output port_hit_t         hit_o
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_PORT);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LO_PORT + 16'd1);

    logic lo_match;
    logic hi_match;

    always_comb begin
        lo_match     = (addr == LO_A);
        hi_match     = wide && (addr == HI_A);
        hit_o.hit    = addr_valid && is_write && is_io && (lo_match || hi_match);
        hit_o.upper  = hi_match;
    end

endmodule

// File: rtl/post_claim_fsm.sv
module post_claim_fsm
    import post_snoop_pkg::*;
#(
    parameter int DUMMY_W = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  claim_policy_e policy,
    input  port_hit_t     hit,
    input  logic          other_claim,
    input  logic          other_ack,
    input  logic          data_valid,
    output logic          claim_o,
    output logic          ack_o,
    output logic          cap_strobe,
    output logic          cap_upper
);
    snoop_state_e         state;
    snoop_state_e         nxt;
    logic [DUMMY_W-1:0]   upper_q;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (hit.hit)
                    nxt = (policy == POL_EAGER) ? ST_OWN_DATA : ST_WIN1;
            end
            ST_WIN1: begin
                if (other_claim)
                    nxt = ST_SNOOP;
                else if (policy == POL_POLITE)
                    nxt = ST_OWN_DATA;
                else
                    nxt = ST_WIN2;
            end
            ST_WIN2:     nxt = other_claim ? ST_SNOOP : ST_IDLE;
            ST_OWN_DATA: if (data_valid) nxt = ST_OWN_ACK;
            ST_OWN_ACK:  nxt = ST_IDLE;
            ST_SNOOP:    if (data_valid && other_ack) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            upper_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && hit.hit)
                upper_q <= DUMMY_W'(hit.upper);
        end
    end

    always_comb begin
        claim_o    = (state == ST_OWN_DATA) || (state == ST_OWN_ACK);
        ack_o      = (state == ST_OWN_ACK);
        cap_strobe = ((state == ST_OWN_DATA) && data_valid) ||
                     ((state == ST_SNOOP) && data_valid && other_ack);
        cap_upper  = upper_q[0];
    end

    AST_EAGER_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hit.hit && policy == POL_EAGER) |=> claim_o); // R2
    AST_POLITE_DEFER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hit.hit && policy == POL_POLITE) |=> !claim_o); // R3
    AST_POLITE_YIELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WIN1 && other_claim) |=> (!claim_o && !ack_o)); // R3
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o); // R6
    AST_ACK_UNDER_CLAIM: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> claim_o); // R6
    AST_ACK_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(data_valid)); // R6

endmodule

// File: rtl/post_code_latch.sv
module post_code_latch
    import post_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  capture_t          cap,
    input  logic              wide,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);
    logic [BYTE_W-1:0] pend_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o  <= '0;
            pend_hi <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cap.strobe) begin
                if (cap.upper) begin
                    pend_hi <= cap.data;
                end else begin
                    code_o  <= wide ? {pend_hi, cap.data} : {{BYTE_W{1'b0}}, cap.data};
                    valid_o <= 1'b1;
                end
            end
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cap.strobe && !cap.upper) |=> $stable(code_o)); // R7
    AST_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R7
    AST_HI_STAGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cap.strobe && cap.upper) |=> !valid_o); // R9

endmodule

// File: rtl/post_hex_view.sv
module post_hex_view
    import post_snoop_pkg::*;
(
    input  logic                    clk,
    input  logic [CODE_W-1:0]       code,
    input  logic                    wide,
    output logic [NDIG*SEG_W-1:0]   seg_o,
    output logic [NDIG-1:0]         en_o
);
    localparam int LO_DIG = NDIG / 2;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        if (g < LO_DIG) begin : g_lo
            assign en_o[g] = 1'b1;
        end else begin : g_hi
            assign en_o[g] = wide;
        end
        assign seg_o[g*SEG_W +: SEG_W] = en_o[g] ? hex_seg(code[g*4 +: 4]) : '0;
    end

    AST_LOW_DIGITS_LIT: assert property (@(posedge clk)
        en_o[LO_DIG-1:0] == '1); // R8

endmodule

// File: rtl/post_code_snooper.sv
module post_code_snooper
    import post_snoop_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] LO_PORT = 16'h0080
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             cfg_policy,
    input  logic                   cfg_wide,
    input  logic                   bus_addr_valid,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_write,
    input  logic                   bus_io,
    input  logic [BYTE_W-1:0]      bus_data,
    input  logic                   bus_data_valid,
    input  logic                   bus_other_claim,
    input  logic                   bus_other_ack,
    output logic                   snp_claim,
    output logic                   snp_ack,
    output logic [CODE_W-1:0]      code_out,
    output logic                   code_valid,
    output logic [NDIG*SEG_W-1:0]  seg_out,
    output logic [NDIG-1:0]        digit_en
);
    port_hit_t     hit;
    capture_t      cap;
    claim_policy_e policy;
    logic          strobe;
    logic          upper;

    assign policy = claim_policy_e'(cfg_policy);

    post_port_decode #(.ADDR_W(ADDR_W), .LO_PORT(LO_PORT)) u_decode (
        .addr_valid (bus_addr_valid),
        .addr       (bus_addr),
        .is_write   (bus_write),
        .is_io      (bus_io),
        .wide       (cfg_wide),
        .hit_o      (hit)
    );

    post_claim_fsm #(.DUMMY_W(1)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .policy      (policy),
        .hit         (hit),
        .other_claim (bus_other_claim),
        .other_ack   (bus_other_ack),
        .data_valid  (bus_data_valid),
        .claim_o     (snp_claim),
        .ack_o       (snp_ack),
        .cap_strobe  (strobe),
        .cap_upper   (upper)
    );

    always_comb begin
        cap.strobe = strobe;
        cap.upper  = upper;
        cap.data   = bus_data;
    end

    post_code_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .wide    (cfg_wide),
        .code_o  (code_out),
        .valid_o (code_valid)
    );

    post_hex_view u_view (
        .clk   (clk),
        .code  (code_out),
        .wide  (cfg_wide),
        .seg_o (seg_out),
        .en_o  (digit_en)
    );

    AST_LISTEN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (cfg_policy[1] && $stable(cfg_policy)) |-> (!snp_ack || $past(!cfg_policy[1]))); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!snp_claim && !snp_ack && !code_valid)); // R11

endmodule

// File: tb/post_code_snooper_test.sv
module post_code_snooper_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_policy;
    logic        cfg_wide;
    logic        bus_addr_valid;
    logic [15:0] bus_addr;
    logic        bus_write;
    logic        bus_io;
    logic [7:0]  bus_data;
    logic        bus_data_valid;
    logic        bus_other_claim;
    logic        bus_other_ack;
    logic        snp_claim;
    logic        snp_ack;
    logic [15:0] code_out;
    logic        code_valid;
    logic [27:0] seg_out;
    logic [3:0]  digit_en;

    int checks   = 0;
    int failures = 0;

    logic        rc [0:6];
    logic        ra [0:6];
    logic        rv [0:6];
    logic [15:0] rcode [0:6];

    always #(CLK_PERIOD/2) clk = ~clk;

    post_code_snooper uut (
        .clk(clk), .rst(rst), .cfg_policy(cfg_policy), .cfg_wide(cfg_wide),
        .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_io(bus_io), .bus_data(bus_data), .bus_data_valid(bus_data_valid),
        .bus_other_claim(bus_other_claim), .bus_other_ack(bus_other_ack),
        .snp_claim(snp_claim), .snp_ack(snp_ack), .code_out(code_out),
        .code_valid(code_valid), .seg_out(seg_out), .digit_en(digit_en)
    );

    function automatic logic [6:0] seg_of(input logic [3:0] n);
        logic [6:0] t [0:15];
        t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
              7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sample(input int i);
        rc[i] = snp_claim;
        ra[i] = snp_ack;
        rv[i] = code_valid;
        rcode[i] = code_out;
    endtask

    // other_at: 0 = no other target, 1/2 = other target claims in that window cycle
    task automatic run_txn(input logic [15:0] a, input logic wr, input logic io,
                           input logic [7:0] d, input int other_at, input logic noise);
        @(negedge clk);
        bus_addr_valid = 1'b1; bus_addr = a; bus_write = wr; bus_io = io;
        sample(0);
        @(negedge clk);
        bus_addr_valid = 1'b0;
        bus_other_claim = (other_at == 1);
        sample(1);
        @(negedge clk);
        bus_other_claim = (other_at == 1) || (other_at == 2);
        sample(2);
        @(negedge clk);
        bus_data_valid = 1'b1; bus_data = d;
        sample(3);
        @(negedge clk);
        bus_other_ack = (other_at != 0) || noise;
        sample(4);
        @(negedge clk);
        bus_data_valid = 1'b0; bus_other_ack = 1'b0; bus_other_claim = 1'b0;
        sample(5);
        @(negedge clk);
        sample(6);
    endtask

    function automatic logic any_claim_or_ack();
        logic r = 1'b0;
        for (int i = 0; i <= 6; i++) r = r | rc[i] | ra[i];
        return r;
    endfunction

    function automatic logic any_valid();
        logic r = 1'b0;
        for (int i = 0; i <= 6; i++) r = r | rv[i];
        return r;
    endfunction

    task automatic t_reset();
        chk("R11 code after reset", code_out, 16'h0000);
        chk("R11 valid after reset", code_valid, 1'b0);
        chk("R11 claim/ack after reset", {snp_claim, snp_ack}, 2'b00);
        chk("R8 digit_en narrow", digit_en, 4'b0011);
        chk("R10 seg at reset", seg_out, {14'h0, 7'h3F, 7'h3F});
    endtask

    task automatic t_eager();
        cfg_policy = 2'd0;
        run_txn(16'h0080, 1'b1, 1'b1, 8'h5A, 0, 1'b0);
        chk("R2 claim in first window cycle", rc[1], 1'b1);
        chk("R6 claim held through ack", {rc[2], rc[3], rc[4]}, 3'b111);
        chk("R6 claim dropped after ack", rc[5], 1'b0);
        chk("R6 single ack cycle", {ra[3], ra[4], ra[5]}, 3'b010);
        chk("R7 code at ack cycle", rcode[4], 16'h005A);
        chk("R7 valid pulse", {rv[3], rv[4], rv[5]}, 3'b010);
        chk("R7 code held", rcode[6], 16'h005A);
    endtask

    task automatic t_polite_free();
        cfg_policy = 2'd1;
        run_txn(16'h0080, 1'b1, 1'b1, 8'h3C, 0, 1'b0);
        chk("R3 no claim in first window cycle", rc[1], 1'b0);
        chk("R3 claim in second window cycle", rc[2], 1'b1);
        chk("R3 code recorded as claimant", rcode[4], 16'h003C);
    endtask

    task automatic t_polite_yield();
        cfg_policy = 2'd1;
        run_txn(16'h0080, 1'b1, 1'b1, 8'hA5, 1, 1'b0);
        chk("R3 yields: no claim or ack", any_claim_or_ack(), 1'b0);
        chk("R3 snooped code", rcode[5], 16'h00A5);
        chk("R7 snooped valid timing", {rv[4], rv[5], rv[6]}, 3'b010);
        chk("R8 narrow code and digits", {code_out, digit_en}, {16'h00A5, 4'b0011});
        chk("R10 narrow segments", seg_out, {14'h0, seg_of(4'hA), seg_of(4'h5)});
    endtask

    task automatic t_listen();
        cfg_policy = 2'd2;
        run_txn(16'h0080, 1'b1, 1'b1, 8'h7E, 2, 1'b0);
        chk("R4 listen never drives", any_claim_or_ack(), 1'b0);
        chk("R4 late foreign claim captured", rcode[5], 16'h007E);
        cfg_policy = 2'd3;
        run_txn(16'h0080, 1'b1, 1'b1, 8'h42, 1, 1'b0);
        chk("R4 policy 3 never drives", any_claim_or_ack(), 1'b0);
        chk("R4 policy 3 captured", rcode[5], 16'h0042);
    endtask

    task automatic t_abort();
        cfg_policy = 2'd2;
        run_txn(16'h0080, 1'b1, 1'b1, 8'hEE, 0, 1'b1);
        chk("R5 aborted: no valid", any_valid(), 1'b0);
        chk("R5 aborted: code unchanged", code_out, 16'h0042);
    endtask

    task automatic t_ignored();
        cfg_policy = 2'd0;
        cfg_wide = 1'b0;
        run_txn(16'h0080, 1'b0, 1'b1, 8'h11, 1, 1'b0);
        chk("R1 io read ignored", {any_claim_or_ack(), any_valid()}, 2'b00);
        run_txn(16'h0080, 1'b1, 1'b0, 8'h22, 1, 1'b0);
        chk("R1 memory write ignored", {any_claim_or_ack(), any_valid()}, 2'b00);
        run_txn(16'h0084, 1'b1, 1'b1, 8'h33, 1, 1'b0);
        chk("R1 other port ignored", {any_claim_or_ack(), any_valid()}, 2'b00);
        run_txn(16'h0081, 1'b1, 1'b1, 8'h44, 1, 1'b0);
        chk("R1 port 0x81 ignored when narrow", {any_claim_or_ack(), any_valid()}, 2'b00);
        chk("R1 code unchanged", code_out, 16'h0042);
    endtask

    task automatic t_wide();
        cfg_policy = 2'd0;
        cfg_wide = 1'b1;
        run_txn(16'h0081, 1'b1, 1'b1, 8'hAB, 0, 1'b0);
        chk("R9 high byte write claimed", rc[1], 1'b1);
        chk("R9 high byte no valid", any_valid(), 1'b0);
        chk("R9 high byte code unchanged", rcode[6], 16'h0042);
        run_txn(16'h0080, 1'b1, 1'b1, 8'hCD, 0, 1'b0);
        chk("R9 wide code formed", rcode[4], 16'hABCD);
        chk("R9 wide valid", rv[4], 1'b1);
        chk("R9 all digits lit", digit_en, 4'b1111);
        chk("R10 wide segments", seg_out,
            {seg_of(4'hA), seg_of(4'hB), seg_of(4'hC), seg_of(4'hD)});
    endtask

    task automatic t_back_narrow();
        cfg_wide = 1'b0;
        run_txn(16'h0080, 1'b1, 1'b1, 8'h11, 0, 1'b0);
        chk("R8 narrow after wide", rcode[4], 16'h0011);
        chk("R10 upper digits blank", seg_out[27:14], 14'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_policy = 2'd0; cfg_wide = 1'b0;
        bus_addr_valid = 1'b0; bus_addr = '0; bus_write = 1'b0; bus_io = 1'b0;
        bus_data = '0; bus_data_valid = 1'b0; bus_other_claim = 1'b0; bus_other_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_eager();
        t_polite_free();
        t_polite_yield();
        t_listen();
        t_abort();
        t_ignored();
        t_wide();
        t_back_narrow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule